// File: doc/BRIEF.md
# Prescaled Capture and Period Timer

This block is a 16-bit up-counter that advances at a rate chosen from a clock prescaler or from edges of an external clock pin. It has two uses. In timer mode, an edge on the capture pin copies the running count into a capture register and the counter keeps going. In cycle-measurement mode, each active capture edge both records the count and restarts the counter from zero, so the capture register holds the time between successive edges, measured in ticks. A compare register raises a match pulse and a sticky flag when the count reaches it. A wrap from all ones sets an overflow flag.

Software talks to the block through a single write port with four addresses: control, count, compare and flag clear. The control register, count, capture value and flags are visible at the outputs at all times. Both pins pass through two synchronizing flip-flops. An edge acts on the third clock edge after the pin changes.

Top module: `cyc_capture_timer`

## Requirements
- R1: After reset the control register, count, compare, capture value, flags and match output are all zero.
- R2: The capture edge is control bit 2 XOR control bit 3. A value of 0 selects the rising edge of `cap_in` and 1 selects the falling edge. A pin change takes effect on the third rising clock edge after it.
- R3: Control bit 1 selects the mode: 0 is timer mode and 1 is cycle-measurement mode.
- R4: In timer mode, while bit 0 (run) is 1, an active capture edge copies the count into the capture register and sets flag bit 0. The count is not disturbed. While run is 0 the capture register holds its value.
- R5: In cycle-measurement mode with run at 1, the first active edge after start only clears the count to 0. Each later edge copies the count into the capture register, clears the count to 0 and sets flag bit 0.
- R6: Control bits 6:4 pick the tick rate: 0 gives clk/2, 1 gives /8, 2 gives /16, 3 gives /32, 4 gives /64, 5 gives /128, 6 gives /256 and 7 gives the external clock. The prescaler runs freely from reset. The count advances by one only on a tick while run is 1, and otherwise holds unless it is written.
- R7: With source 7, each edge of `ext_clk_in` is one tick. Control bit 7 picks the edge: 0 counts rising edges and 1 counts falling edges.
- R8: A write to control bits 6:4 is taken only if run and the mode bit are both 0 at the time of the write. Otherwise the field keeps its old value.
- R9: A control write that would set the mode bit is ignored for that bit while run is 1.
- R10: When the count equals the compare value on a tick while running, `match_o` pulses high for one cycle and flag bit 1 is set.
- R11: A tick while running with the count at 0xFFFF sets flag bit 2, and the count becomes 0x0000.
- R12: Flags are sticky. Writing address 3 clears each flag whose data bit is 1. If a flag is set and cleared in the same cycle, the set wins. Address 1 loads the count, address 2 loads the compare value, and address 0 loads the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Target: 0 control, 1 count, 2 compare, 3 flag clear |
| wr_data | input | 16 | Write data |
| cap_in | input | 1 | Capture pin (asynchronous) |
| ext_clk_in | input | 1 | External count clock pin (asynchronous) |
| ctrl_o | output | 8 | Control register |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Capture register |
| flags_o | output | 3 | Sticky flags: bit 0 capture, bit 1 match, bit 2 overflow |
| match_o | output | 1 | One-cycle compare-match pulse |

## Verification
The assertions check four rules on every cycle. The count and capture register hold their values while run is 0. The clock-select field and the mode bit obey their write guards. A match pulse always comes with its flag, and the overflow flag rises only after the count was all ones. The bench's scenarios cover the rest: the XOR edge choice, the first-edge arming in cycle-measurement mode, the exact tick count over a window at a chosen rate, and external-clock edge counting. A lockstep model in the bench compares every output on every cycle of a long random phase.

// File: rtl/cyc_capture_timer.sv
module cyc_capture_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cap_in,
  input  logic             ext_clk_in,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic [2:0]       flags_o,
  output logic             match_o
);
  localparam int PRE_W = 8;

  logic [7:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cmp_q, cap_q;
  logic [2:0]       flg_q;
  logic             match_q, armed_q;
  logic [PRE_W-1:0] pre_q, pmask;
  logic [2:0]       csync_q, esync_q;

  wire       run      = ctrl_q[0];
  wire       cyc_mode = ctrl_q[1];
  wire [2:0] csel     = ctrl_q[6:4];

  wire cap_fall = ctrl_q[2] ^ ctrl_q[3];
  wire cap_edge = cap_fall ? (csync_q[2] & ~csync_q[1]) : (csync_q[1] & ~csync_q[2]);
  wire ext_edge = ctrl_q[7] ? (esync_q[2] & ~esync_q[1]) : (esync_q[1] & ~esync_q[2]);

  always_comb begin
    case (csel)
      3'd0:    pmask = 8'h01;
      3'd1:    pmask = 8'h07;
      3'd2:    pmask = 8'h0F;
      3'd3:    pmask = 8'h1F;
      3'd4:    pmask = 8'h3F;
      3'd5:    pmask = 8'h7F;
      default: pmask = 8'hFF;
    endcase
  end

  wire pre_tick = &(pre_q | ~pmask);
  wire tick     = (csel == 3'd7) ? ext_edge : pre_tick;
  wire adv      = run & tick;
  wire hit      = adv & (cnt_q == cmp_q);
  wire wrap     = adv & (&cnt_q);
  wire grab     = run & cap_edge & (~cyc_mode | armed_q);
  wire restart  = run & cyc_mode & cap_edge;

  wire wr_ctrl = wr_en & (wr_addr == 2'd0);
  wire wr_cnt  = wr_en & (wr_addr == 2'd1);
  wire wr_cmp  = wr_en & (wr_addr == 2'd2);
  wire wr_clr  = wr_en & (wr_addr == 2'd3);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d[0] = wr_data[0];
      ctrl_d[2] = wr_data[2];
      ctrl_d[3] = wr_data[3];
      ctrl_d[7] = wr_data[7];
      if (!(wr_data[1] && run))
        ctrl_d[1] = wr_data[1];
      if (!run && !cyc_mode)
        ctrl_d[6:4] = wr_data[6:4];
    end
  end

  wire [2:0] clr_mask = wr_clr ? wr_data[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
      cap_q   <= '0;
      flg_q   <= '0;
      match_q <= 1'b0;
      armed_q <= 1'b0;
      pre_q   <= '0;
      csync_q <= '0;
      esync_q <= '0;
    end else begin
      pre_q   <= pre_q + PRE_W'(1);
      csync_q <= {csync_q[1:0], cap_in};
      esync_q <= {esync_q[1:0], ext_clk_in};
      ctrl_q  <= ctrl_d;
      if (wr_cmp) cmp_q <= wr_data;
      if (wr_cnt)       cnt_q <= wr_data;
      else if (restart) cnt_q <= '0;
      else if (adv)     cnt_q <= cnt_q + CNT_W'(1);
      if (grab) cap_q <= cnt_q;
      flg_q   <= (flg_q & ~clr_mask) | {wrap, hit, grab};
      match_q <= hit;
      armed_q <= run & cyc_mode & (armed_q | cap_edge);
    end
  end

  assign ctrl_o    = ctrl_q;
  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign flags_o   = flg_q;
  assign match_o   = match_q;
endmodule

// File: rtl/cyc_capture_timer_chk.sv
module cyc_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o,
  input logic [2:0]       flags_o,
  input logic             match_o
);
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[0] && !wr_en) |=> $stable(count_o)); // R6
  AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[0] |=> $stable(capture_o)); // R4
  AST_CLKSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] || ctrl_o[1]) |=> $stable(ctrl_o[6:4])); // R8
  AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[0] && !ctrl_o[1]) |=> !ctrl_o[1]); // R9
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> flags_o[1]); // R10
  AST_WRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[2]) |-> ($past(count_o) == {CNT_W{1'b1}})); // R11
endmodule

bind cyc_capture_timer cyc_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_o(ctrl_o), .count_o(count_o),
  .capture_o(capture_o), .flags_o(flags_o), .match_o(match_o));

// File: tb/cyc_capture_timer_test.sv
module cyc_capture_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cap_in = 1'b0, ext_clk_in = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] ctrl_o;
  logic [15:0] count_o, capture_o;
  logic [2:0] flags_o;
  logic match_o;

  int n_chk = 0, n_fail = 0, n_match = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cyc_capture_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_in(cap_in), .ext_clk_in(ext_clk_in), .ctrl_o(ctrl_o),
    .count_o(count_o), .capture_o(capture_o), .flags_o(flags_o), .match_o(match_o));

  // Lockstep reference model built from the requirements
  logic [7:0] m_ctrl;
  logic [15:0] m_cnt, m_cmp, m_cap;
  logic [2:0] m_flg;
  logic m_match, m_armed;
  int m_pre;
  logic [2:0] m_cs, m_es;

  function automatic int period_of(input logic [2:0] s);
    case (s)
      3'd0: return 2;   3'd1: return 8;   3'd2: return 16;  3'd3: return 32;
      3'd4: return 64;  3'd5: return 128; default: return 256;
    endcase
  endfunction

  function automatic logic edge_of(input logic fall, input logic now, input logic prev);
    return fall ? (prev && !now) : (now && !prev);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_cmp = 0; m_cap = 0; m_flg = 0;
      m_match = 0; m_armed = 0; m_pre = 0; m_cs = 0; m_es = 0;
    end else begin
      logic ce, ee, tk, run, md;
      logic [15:0] n_cnt, n_cap;
      logic [2:0] set;
      logic [7:0] n_ctrl;
      run = m_ctrl[0]; md = m_ctrl[1];
      ce = edge_of(m_ctrl[2] ^ m_ctrl[3], m_cs[1], m_cs[2]);
      ee = edge_of(m_ctrl[7], m_es[1], m_es[2]);
      tk = (m_ctrl[6:4] == 3'd7) ? ee : (((m_pre + 1) % period_of(m_ctrl[6:4])) == 0);
      n_cnt = m_cnt; n_cap = m_cap; set = 0; n_ctrl = m_ctrl;
      if (run && tk) begin
        if (m_cnt == m_cmp) set[1] = 1;
        if (m_cnt == 16'hFFFF) set[2] = 1;
        n_cnt = m_cnt + 1;
      end
      if (run && ce) begin
        if (!md) begin n_cap = m_cnt; set[0] = 1; end
        else begin
          if (m_armed) begin n_cap = m_cnt; set[0] = 1; end
          n_cnt = 0;
        end
      end
      m_match = set[1];
      if (!run || !md) m_armed = 0; else if (ce) m_armed = 1;
      m_flg = m_flg | set;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            n_ctrl[0] = wr_data[0]; n_ctrl[2] = wr_data[2];
            n_ctrl[3] = wr_data[3]; n_ctrl[7] = wr_data[7];
            if (!run || !wr_data[1]) n_ctrl[1] = wr_data[1];
            if (!run && !md) n_ctrl[6:4] = wr_data[6:4];
          end
          2'd1: n_cnt = wr_data;
          2'd2: m_cmp = wr_data;
          default: m_flg = (m_flg & ~wr_data[2:0]) | set;
        endcase
      end
      m_ctrl = n_ctrl; m_cnt = n_cnt; m_cap = n_cap;
      m_pre = (m_pre + 1) % 256;
      m_cs = {m_cs[1:0], cap_in};
      m_es = {m_es[1:0], ext_clk_in};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 model count", count_o, m_cnt);
      chk("R4 model capture", capture_o, m_cap);
      chk("R12 model flags", flags_o, m_flg);
      chk("R8 model ctrl", ctrl_o, m_ctrl);
      chk("R10 model match", match_o, m_match);
      if (match_o) n_match++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_o, 0); chk("R1 count", count_o, 0);
    chk("R1 capture", capture_o, 0); chk("R1 flags", flags_o, 0);
    chk("R1 match", match_o, 0);

    // R6: clk/32 for exactly 320 counting edges gives 10 ticks
    wr(1, 0); wr(2, 16'hFFFF);
    wr(0, 16'h0031);
    repeat (319) @(negedge clk);
    wr(0, 16'h0030);
    chk("R6 ten ticks at clk/32", count_o, 10);

    // R8: clock select locked while running
    wr(0, 16'h0031); wr(0, 16'h0001);
    chk("R8 sel held while running", ctrl_o[6:4], 3);
    wr(0, 16'h0000);
    chk("R8 sel held on stopping write", ctrl_o, 8'h30);
    wr(0, 16'h0000);
    chk("R8 sel taken when idle", ctrl_o, 0);

    // R9: mode set ignored while running
    wr(0, 16'h0001); wr(0, 16'h0003);
    chk("R9 mode not set while running", ctrl_o[1], 0);

    // R2 / R4: polarity inversion selects falling edge
    wr(3, 7); wr(0, 16'h0009);
    cap_in = 1; repeat (5) @(negedge clk);
    chk("R2 rising ignored when inverted", flags_o[0], 0);
    cap_in = 0; repeat (5) @(negedge clk);
    chk("R2 falling captured when inverted", flags_o[0], 1);
    chk("R4 capture nonzero", capture_o != 0, 1);
    chk("R4 timer count not cleared", count_o >= capture_o, 1);
    wr(3, 1); wr(0, 16'h000D);
    cap_in = 1; repeat (5) @(negedge clk);
    chk("R2 both bits set picks rising", flags_o[0], 1);

    // R3 / R5: cycle measurement, 30-cycle period at clk/2
    wr(0, 16'h000C); wr(1, 0); wr(3, 7);
    wr(0, 16'h000E);
    chk("R3 mode set while stopped", ctrl_o[1], 1);
    wr(0, 16'h000F);
    cap_in = 0; repeat (6) @(negedge clk);
    cap_in = 1; repeat (6) @(negedge clk);
    chk("R5 first edge no capture", flags_o[0], 0);
    chk("R5 first edge clears count", count_o <= 3, 1);
    repeat (14) @(negedge clk);
    cap_in = 0; repeat (10) @(negedge clk);
    cap_in = 1; repeat (6) @(negedge clk);
    chk("R5 second edge captures", flags_o[0], 1);
    chk("R5 period in ticks", (capture_o == 14) || (capture_o == 15), 1);

    // R10: compare match pulse
    wr(0, 16'h000C); wr(0, 16'h0000); wr(1, 0); wr(2, 5); wr(3, 7);
    n_match = 0;
    wr(0, 16'h0001);
    repeat (20) @(negedge clk);
    chk("R10 match flag", flags_o[1], 1);
    chk("R10 single pulse", n_match, 1);

    // R11 / R12: overflow and clear
    wr(0, 16'h0000); wr(2, 16'h8000); wr(1, 16'hFFF8); wr(3, 7);
    wr(0, 16'h0001);
    repeat (30) @(negedge clk);
    chk("R11 overflow flag", flags_o[2], 1);
    chk("R11 wrapped count small", count_o < 16, 1);
    wr(3, 4);
    chk("R12 overflow cleared", flags_o[2], 0);

    // R7: external clock, falling then rising
    wr(0, 16'h0000); wr(1, 0); wr(0, 16'h00F0); wr(0, 16'h00F1);
    for (int i = 0; i < 3; i++) begin
      ext_clk_in = 1; repeat (4) @(negedge clk);
      ext_clk_in = 0; repeat (4) @(negedge clk);
    end
    chk("R7 three falling edges", count_o, 3);
    wr(0, 16'h0070); wr(1, 0); wr(0, 16'h0071);
    for (int i = 0; i < 2; i++) begin
      ext_clk_in = 1; repeat (4) @(negedge clk);
      ext_clk_in = 0; repeat (4) @(negedge clk);
    end
    chk("R7 two rising edges", count_o, 2);

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 100;
      if ($urandom % 8 == 0) cap_in = ~cap_in;
      if ($urandom % 3 == 0) ext_clk_in = ~ext_clk_in;
      if (r < 7) begin
        wr_en = 1; wr_addr = 2'($urandom % 4);
        wr_data = (wr_addr == 2'd1 && ($urandom % 2 == 0)) ? 16'hFFF0 : 16'($urandom);
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    finish_run();
  end
endmodule